// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block is the control front end of a small synchronous burst SRAM. On every rising clock edge it looks at three chip selects, two address strobes, a burst-advance input and the write controls. It then places the clock in one of a fixed set of cycle kinds. That kind decides which address is used, which bytes of the internal array are written and whether read data is loaded into the output register. The kind is reported on a 3-bit output, so the surrounding logic and the bench can follow the sequence.

The processor-side strobe always starts a read, even when the write controls are active. A write therefore starts either on a later clock of that burst or through the controller-side strobe. The data bus is not bidirectional here. The block gives a read-data register and a drive-enable output, and that enable follows the output-enable pin without a clock. Writes mask it. A sleep input stops all cycles two clocks after it is sampled high, and it releases them two clocks after it is sampled low. The array keeps its contents through sleep.

A four-state machine (IDLE, READ, WRITE, SLEEP) records what the last clock did:
- Any deselect takes it to IDLE.
- Any read kind takes it to READ.
- Any write kind takes it to WRITE.
- A sleep clock takes it to SLEEP.
- The first non-sleep clock leaves SLEEP through the same rules.

Burst continue and suspend are only possible from READ or WRITE.

Top module: `sbc_ctrl`

## Requirements
- R1: The internal write is active when `gw_n` is low, and then all four bytes are written. Otherwise it is active when `bwe_n` is low and at least one `bw_n[i]` is low, and then only byte i (bits 8i+7:8i) is written for each low `bw_n[i]`. With `bwe_n` low and all `bw_n` high, the cycle is a read.
- R2: `adsp_n` low with `ce1_n` low, `ce2` high and `ce3_n` low gives a begin-read at `addr`, whatever `gw_n`, `bwe_n` and `bw_n` are. The array is not written.
- R3: `adsc_n` low with the device selected (and the processor strobe not taken) gives begin-write at `addr` when the write is active, and begin-read at `addr` otherwise.
- R4: The following cases are deselect clocks. A deselect uses no address, writes nothing and leaves `dq_oe` low.
  - `adsp_n` low with `ce1_n` low and either `ce2` low or `ce3_n` high.
  - `adsc_n` low with `ce1_n` high, `ce2` low or `ce3_n` high.

  `ce1_n` high blocks the processor strobe.
- R5: With no strobe taken after a read or write clock, the cycle kind depends on the write and on `adv_n`:

  | Write | `adv_n` | Cycle kind | Address |
  |---|---|---|---|
  | inactive | low | continue-read | next |
  | inactive | high | suspend-read | current |
  | active | low | continue-write | next |
  | active | high | begin-write | current |

  The next address steps the low two bits linearly with wrap (…01→10→11→00), and the upper bits are kept.
- R6: With no strobe taken while the machine is IDLE, the clock is a deselect.
- R7: A read clock loads the addressed word into `rdata` at that edge. `dq_oe` is high exactly when the last clock was a read and `oe_n` is low. `dq_oe` follows `oe_n` without waiting for a clock.
- R8: After a write, deselect or sleep clock, `dq_oe` is low whatever `oe_n` is.
- R9: Sleep timing and behaviour:
  - When `zz` is first sampled high at edge k, the clocks at k and k+1 still run. The clocks from k+2 on are sleep clocks: nothing is written or read and `sleep` is high.
  - When `zz` is first sampled low at edge m, the clocks at m and m+1 are still sleep clocks, and the clock at m+2 runs normally.
  - Array contents are kept through sleep.
- R10: `cycle_kind` gives the kind of the last clock, with this encoding:

  | Code | Kind |
  |---|---|
  | 0 | deselect |
  | 1 | begin-read |
  | 2 | continue-read |
  | 3 | suspend-read |
  | 4 | begin-write |
  | 5 | continue-write |
  | 6 | sleep |

- R11: While `rst_n` is low and after its release, `cycle_kind` is 0, `dq_oe` is 0 and `sleep` is 0 until the first clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | AW | External word address |
| ce1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select 2, active high |
| ce3_n | input | 1 | Chip select 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bw_n | input | DW/8 | Per-byte write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |
| cycle_kind | output | 3 | Kind of the last clock (R10 encoding) |
| sleep | output | 1 | High while in the sleep state |

## Verification
A wrong state register shows at the ports one clock after the fault. An IDLE that should be READ turns a suspend into a deselect, so `cycle_kind` reads 0 and `dq_oe` drops. A READ that should be WRITE raises `dq_oe` during a write. A burst address that steps wrongly, or a byte mask that lands on the wrong lane, shows up one clock later. It appears as an `rdata` word that differs from the bench's reference array on a readback. A sleep pipeline that is one stage short or long moves the rising and falling edges of `sleep` by one clock. It also makes a write that should have been ignored appear in the array, or lets through a write that should have run.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        CK_DESEL    = 3'd0,
        CK_BEGIN_RD = 3'd1,
        CK_CONT_RD  = 3'd2,
        CK_SUSP_RD  = 3'd3,
        CK_BEGIN_WR = 3'd4,
        CK_CONT_WR  = 3'd5,
        CK_SLEEP    = 3'd6
    } cycle_kind_t;

    typedef enum logic [1:0] {
        AS_EXT = 2'd0,
        AS_CUR = 2'd1,
        AS_NXT = 2'd2
    } addr_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_SLEEP = 2'd3
    } ctrl_state_t;

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
    import sbc_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic              sleep_req,
    input  logic              burst_live,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [NB-1:0]     bw_n,
    output cycle_kind_t       kind,
    output addr_sel_t         sel,
    output logic [NB-1:0]     byte_we
);

    logic [NB-1:0] wr_mask;
    logic          wr_act;
    logic          selected;

    always_comb begin
        if (!gw_n)       wr_mask = '1;
        else if (!bwe_n) wr_mask = ~bw_n;
        else             wr_mask = '0;
        wr_act   = |wr_mask;
        selected = !ce1_n && ce2 && !ce3_n;

        kind = CK_DESEL;
        sel  = AS_CUR;
        if (sleep_req) begin
            kind = CK_SLEEP;
        end else if (!adsp_n && !ce1_n) begin
            if (selected) begin
                kind = CK_BEGIN_RD;
                sel  = AS_EXT;
            end
        end else if (!adsc_n) begin
            if (selected) begin
                kind = wr_act ? CK_BEGIN_WR : CK_BEGIN_RD;
                sel  = AS_EXT;
            end
        end else if (burst_live) begin
            if (wr_act) kind = adv_n ? CK_BEGIN_WR : CK_CONT_WR;
            else        kind = adv_n ? CK_SUSP_RD  : CK_CONT_RD;
            sel = adv_n ? AS_CUR : AS_NXT;
        end

        byte_we = (kind == CK_BEGIN_WR || kind == CK_CONT_WR) ? wr_mask : '0;
    end

endmodule

// File: rtl/sbc_addr.sv
module sbc_addr
    import sbc_pkg::*;
#(
    parameter int AW = 4,
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  addr_sel_t     sel,
    input  logic          load,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] use_addr
);

    logic [AW-1:0] cur_q;
    logic [BB-1:0] step;
    logic [AW-1:0] nxt;

    always_comb begin
        step = cur_q[BB-1:0] + 1'b1;
        nxt  = {cur_q[AW-1:BB], step};
        unique case (sel)
            AS_EXT:  use_addr = ext_addr;
            AS_NXT:  use_addr = nxt;
            default: use_addr = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cur_q <= '0;
        else if (load) cur_q <= use_addr;
    end

endmodule

// File: rtl/sbc_array.sv
module sbc_array #(
    parameter int AW = 4,
    parameter int NB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [NB-1:0]     we,
    input  logic              re,
    input  logic [NB*8-1:0]   wdata,
    output logic [NB*8-1:0]   rdata
);

    localparam int DEPTH = 1 << AW;

    logic [NB*8-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (we[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[addr];
    end

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 32,
    parameter int BB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adsp_n,
    input  logic              adsc_n,
    input  logic              adv_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [DW/8-1:0]   bw_n,
    input  logic              oe_n,
    input  logic              zz,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              dq_oe,
    output logic [2:0]        cycle_kind,
    output logic              sleep
);

    localparam int NB = DW / 8;

    ctrl_state_t   state_q, state_d;
    cycle_kind_t   kind, kind_q;
    addr_sel_t     sel;
    logic [NB-1:0] byte_we;
    logic [AW-1:0] use_addr;
    logic          zz_q1, sleep_req;
    logic          burst_live, load, rd_kind;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zz_q1     <= 1'b0;
            sleep_req <= 1'b0;
        end else begin
            zz_q1     <= zz;
            sleep_req <= zz_q1;
        end
    end

    assign burst_live = (state_q == ST_READ) || (state_q == ST_WRITE);

    sbc_decode #(.NB(NB)) u_dec (
        .sleep_req (sleep_req),
        .burst_live(burst_live),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .ce1_n     (ce1_n),
        .ce2       (ce2),
        .ce3_n     (ce3_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .kind      (kind),
        .sel       (sel),
        .byte_we   (byte_we)
    );

    assign rd_kind = (kind == CK_BEGIN_RD) || (kind == CK_CONT_RD) || (kind == CK_SUSP_RD);
    assign load    = (kind != CK_DESEL) && (kind != CK_SLEEP);

    sbc_addr #(.AW(AW), .BB(BB)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .load    (load),
        .ext_addr(addr),
        .use_addr(use_addr)
    );

    sbc_array #(.AW(AW), .NB(NB)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (use_addr),
        .we   (byte_we),
        .re   (rd_kind),
        .wdata(wdata),
        .rdata(rdata)
    );

    // next-state decision from the classified clock
    always_comb begin
        unique case (kind)
            CK_SLEEP:                           state_d = ST_SLEEP;
            CK_BEGIN_RD, CK_CONT_RD, CK_SUSP_RD: state_d = ST_READ;
            CK_BEGIN_WR, CK_CONT_WR:            state_d = ST_WRITE;
            default:                            state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= CK_DESEL;
        end else begin
            state_q <= state_d;
            kind_q  <= kind;
        end
    end

    // outputs
    always_comb begin
        dq_oe      = (state_q == ST_READ) && !oe_n;
        sleep      = (state_q == ST_SLEEP);
        cycle_kind = kind_q;
    end

endmodule

// File: rtl/sbc_ctrl_chk.sv
module sbc_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       adsp_n,
    input logic       adsc_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       ce3_n,
    input logic       zz,
    input logic       sleep_req,
    input logic [2:0] cycle_kind,
    input logic       dq_oe,
    input logic       sleep
);

    logic [1:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    a_r2_adsp_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0) && $past(!adsp_n && !ce1_n && ce2 && !ce3_n && !sleep_req)
        |-> cycle_kind == 3'd1);

    a_r4_ce1_deselects: assert property (@(posedge clk) disable iff (!rst_n)
        (seen != 2'd0) && $past(ce1_n && !adsc_n && !sleep_req)
        |-> cycle_kind == 3'd0);

    a_r8_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_kind == 3'd0 || cycle_kind == 3'd4 || cycle_kind == 3'd5 || cycle_kind == 3'd6)
        |-> !dq_oe);

    a_r9_sleep_onset: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd3) && $rose(sleep) |-> $past(zz, 2) && $past(zz, 3));

    a_r9_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (cycle_kind == 3'd6) && !dq_oe);

endmodule

bind sbc_ctrl sbc_ctrl_chk u_chk (.*);

// File: tb/sbc_ctrl_test.sv
module sbc_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic        oe_n = 1'b1, zz = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dq_oe;
    logic [2:0]  cycle_kind;
    logic        sleep;

    int errors = 0;
    int checks = 0;
    logic [31:0] ref_mem [16];

    always #10 clk = ~clk;

    sbc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe),
        .cycle_kind(cycle_kind), .sleep(sleep)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic p_n, input logic c_n, input logic a_n, input logic e1_n,
                       input logic e2, input logic e3_n, input logic g_n, input logic b_n,
                       input logic [3:0] bws_n, input logic [3:0] ad, input logic [31:0] wd);
        @(negedge clk);
        adsp_n = p_n; adsc_n = c_n; adv_n = a_n; ce1_n = e1_n; ce2 = e2; ce3_n = e3_n;
        gw_n = g_n; bwe_n = b_n; bw_n = bws_n; addr = ad; wdata = wd;
        @(posedge clk);
        #1;
    endtask

    task automatic wr_ext(input logic [3:0] ad, input logic [31:0] wd);
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, ad, wd);
        ref_mem[ad] = wd;
    endtask

    task automatic rd_ext(input logic [3:0] ad);
        cyc(1, 0, 1, 0, 1, 0, 1, 1, 4'hF, ad, 32'h0);
    endtask

    task automatic desel();
        cyc(1, 0, 1, 1, 1, 0, 1, 1, 4'hF, 4'h0, 32'h0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++) wr_ext(i[3:0], 32'h5A000000 | (i * 32'h00010203));
        desel();
    endtask

    task automatic t_byte_writes();
        logic [31:0] exp;
        oe_n = 1'b0;
        wr_ext(4'd4, 32'h01234567);
        chk(cycle_kind == 3'd4, "R3 begin-write kind", {29'd0, cycle_kind}, 32'd4);
        chk(dq_oe == 1'b0, "R8 no drive on write", {31'd0, dq_oe}, 32'd0);
        exp = (ref_mem[5] & 32'hFF00FF00) | (32'hDEADBEEF & 32'h00FF00FF);
        cyc(1, 0, 1, 0, 1, 0, 1, 0, 4'b1010, 4'd5, 32'hDEADBEEF);
        ref_mem[5] = exp;
        chk(cycle_kind == 3'd4, "R1 byte write kind", {29'd0, cycle_kind}, 32'd4);
        cyc(1, 0, 1, 0, 1, 0, 1, 0, 4'hF, 4'd5, 32'hFFFFFFFF);
        chk(cycle_kind == 3'd1, "R1 bwe without bytes reads", {29'd0, cycle_kind}, 32'd1);
        chk(rdata == ref_mem[5], "R1 byte lanes merged", rdata, ref_mem[5]);
        chk(dq_oe == 1'b1, "R7 drive on read", {31'd0, dq_oe}, 32'd1);
        rd_ext(4'd4);
        chk(rdata == ref_mem[4], "R1 global write all bytes", rdata, ref_mem[4]);
    endtask

    task automatic t_adsp_forces_read();
        cyc(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 4'd6, 32'hBAD0BAD0);
        chk(cycle_kind == 3'd1, "R2 processor strobe reads", {29'd0, cycle_kind}, 32'd1);
        chk(rdata == ref_mem[6], "R2 read data unchanged", rdata, ref_mem[6]);
        cyc(1, 1, 1, 0, 1, 0, 0, 1, 4'hF, 4'd0, 32'h66666666);
        ref_mem[6] = 32'h66666666;
        chk(cycle_kind == 3'd4, "R5 write at current after strobe", {29'd0, cycle_kind}, 32'd4);
        rd_ext(4'd6);
        chk(rdata == ref_mem[6], "R5 current-address write landed", rdata, ref_mem[6]);
    endtask

    task automatic t_burst_read();
        logic [3:0] a;
        rd_ext(4'd9);
        chk(rdata == ref_mem[9], "R3 burst first beat", rdata, ref_mem[9]);
        a = 4'd9;
        for (int i = 0; i < 3; i++) begin
            a = {a[3:2], a[1:0] + 2'd1};
            cyc(1, 1, 0, 0, 1, 0, 1, 1, 4'hF, 4'd0, 32'h0);
            chk(cycle_kind == 3'd2, "R5 continue-read kind", {29'd0, cycle_kind}, 32'd2);
            chk(rdata == ref_mem[a], "R5 linear wrap beat", rdata, ref_mem[a]);
        end
        cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, 4'd0, 32'h0);
        chk(cycle_kind == 3'd3, "R5 suspend-read kind", {29'd0, cycle_kind}, 32'd3);
        chk(rdata == ref_mem[8], "R5 suspend holds address", rdata, ref_mem[8]);
    endtask

    task automatic t_burst_write();
        wr_ext(4'd14, 32'hC0DE000E);
        for (int i = 1; i < 4; i++) begin
            logic [3:0] a;
            a = {2'b11, 2'(2 + i)};
            cyc(1, 1, 0, 0, 1, 0, 0, 1, 4'hF, 4'd0, 32'hC0DE0000 | i);
            ref_mem[a] = 32'hC0DE0000 | i;
            chk(cycle_kind == 3'd5, "R5 continue-write kind", {29'd0, cycle_kind}, 32'd5);
        end
        for (int i = 12; i < 16; i++) begin
            rd_ext(i[3:0]);
            chk(rdata == ref_mem[i], "R5 burst write readback", rdata, ref_mem[i]);
        end
    endtask

    task automatic t_deselect();
        oe_n = 1'b0;
        cyc(1, 0, 1, 1, 1, 0, 0, 1, 4'hF, 4'd2, 32'hEEEEEEEE);
        chk(cycle_kind == 3'd0, "R4 ce1 high deselects", {29'd0, cycle_kind}, 32'd0);
        chk(dq_oe == 1'b0, "R4 no drive when deselected", {31'd0, dq_oe}, 32'd0);
        cyc(1, 1, 1, 0, 1, 0, 1, 1, 4'hF, 4'd0, 32'h0);
        chk(cycle_kind == 3'd0, "R6 idle without strobe", {29'd0, cycle_kind}, 32'd0);
        cyc(0, 1, 1, 0, 0, 0, 1, 1, 4'hF, 4'd2, 32'h0);
        chk(cycle_kind == 3'd0, "R4 ce2 low deselects", {29'd0, cycle_kind}, 32'd0);
        cyc(1, 0, 1, 0, 1, 1, 0, 1, 4'hF, 4'd2, 32'hEEEEEEEE);
        chk(cycle_kind == 3'd0, "R4 ce3 high deselects", {29'd0, cycle_kind}, 32'd0);
        rd_ext(4'd2);
        chk(rdata == ref_mem[2], "R4 deselect wrote nothing", rdata, ref_mem[2]);
        cyc(0, 1, 1, 1, 1, 0, 1, 1, 4'hF, 4'd7, 32'h0);
        chk(cycle_kind == 3'd3, "R4 ce1 blocks processor strobe", {29'd0, cycle_kind}, 32'd3);
        chk(rdata == ref_mem[2], "R4 blocked strobe kept address", rdata, ref_mem[2]);
    endtask

    task automatic t_oe_async();
        rd_ext(4'd3);
        @(negedge clk);
        oe_n = 1'b1;
        #2;
        chk(dq_oe == 1'b0, "R7 oe high releases bus", {31'd0, dq_oe}, 32'd0);
        oe_n = 1'b0;
        #2;
        chk(dq_oe == 1'b1, "R7 oe low drives without clock", {31'd0, dq_oe}, 32'd1);
    endtask

    task automatic t_sleep();
        desel();
        zz = 1'b1;
        wr_ext(4'd2, 32'h22222222);
        chk(cycle_kind == 3'd4 && sleep == 1'b0, "R9 edge k still runs", {28'd0, sleep, cycle_kind}, 32'd4);
        wr_ext(4'd3, 32'h33333333);
        chk(cycle_kind == 3'd4 && sleep == 1'b0, "R9 edge k+1 still runs", {28'd0, sleep, cycle_kind}, 32'd4);
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 4'd1, 32'h11111111);
        chk(cycle_kind == 3'd6 && sleep == 1'b1, "R9 edge k+2 sleeps", {28'd0, sleep, cycle_kind}, 32'hE);
        chk(dq_oe == 1'b0, "R8 no drive in sleep", {31'd0, dq_oe}, 32'd0);
        zz = 1'b0;
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 4'd1, 32'h11111111);
        chk(cycle_kind == 3'd6, "R9 edge m still asleep", {29'd0, cycle_kind}, 32'd6);
        cyc(1, 0, 1, 0, 1, 0, 0, 1, 4'hF, 4'd1, 32'h11111111);
        chk(sleep == 1'b1, "R9 edge m+1 still asleep", {31'd0, sleep}, 32'd1);
        rd_ext(4'd1);
        chk(cycle_kind == 3'd1 && sleep == 1'b0, "R9 edge m+2 resumes", {28'd0, sleep, cycle_kind}, 32'd1);
        chk(rdata == ref_mem[1], "R9 sleep writes ignored", rdata, ref_mem[1]);
        rd_ext(4'd3);
        chk(rdata == ref_mem[3], "R9 pre-sleep write kept", rdata, ref_mem[3]);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(cycle_kind == 3'd0 && dq_oe == 1'b0 && sleep == 1'b0, "R11 reset state",
            {27'd0, sleep, dq_oe, cycle_kind}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(cycle_kind == 3'd0 && dq_oe == 1'b0, "R10 R11 kind after release",
            {29'd0, cycle_kind}, 32'd0);
        t_fill();
        t_byte_writes();
        t_adsp_forces_read();
        t_burst_read();
        t_burst_write();
        t_deselect();
        t_oe_async();
        t_sleep();
        summary();
        $finish;
    end

endmodule